// File: doc/BRIEF.md
# Two-Wire Write-Only Register Port

This block is a slave on a two-wire serial control bus. It works in the system clock domain. Both the serial clock and the bidirectional data line are sampled through synchronizer flops. The data line is open-drain, so the block never drives it high. Its only output toward the pad is a "pull low" enable that the pad logic turns into a wired-AND with the external pull-up.

A transfer opens with a start condition and then a byte that carries a 7-bit device address and a direction bit. After that come three bytes: an 8-bit register address, the upper data byte and the lower data byte. The block acknowledges each byte it accepts. When the last byte has been acknowledged, the block emits a single-cycle write request into a small register bank.

The write request is a valid-only stream with no ready. The serial link cannot stall because clock stretching is not provided, so a consumer of `wr_valid_o` must take every beat in the cycle it appears. In the bank, register 0 is a fixed identity word and register 1 is a fixed revision code. A write of any value to address 0 returns every writable register to its default.

Top module: `twowire_regbank`

## Requirements
- R1: A start is a falling edge on the data line while the serial clock is high. A stop is a rising edge on the data line while the clock is high. A start seen while idle opens a frame.
- R2: The first byte is shifted in MSB first on rising serial clock edges, as seven address bits followed by a direction bit. When the address equals DEV_ADDR (default 7'b0011010) and the direction bit is 0, the data line is pulled low from the fall of the 8th clock to the fall of the 9th clock.
- R3: On an address mismatch the block returns to idle with no acknowledge. It stays silent on the rest of the frame and does not write.
- R4: A first byte whose direction bit is 1 (a read) is not acknowledged and returns the block to idle.
- R5: In an accepted frame, each of the three following bytes (register address, data bits 15:8, data bits 7:0) is acknowledged in its 9th clock.
- R6: The pull-low enable changes only while the serial clock is low.
- R7: One system clock after the fall of the last acknowledge clock, `wr_valid_o` is high for exactly one cycle. In that cycle `wr_addr_o` carries the first payload byte and `wr_data_o` carries the second byte followed by the third byte.
- R8: A start or stop inside a frame returns the block to idle without a write. The block does not treat that start as the opening of a new frame.
- R9: A write of any value to register address 0 returns every writable register to its default.
- R10: Reading address 0 returns CHIP_ID (default 16'hC0DE). Reading address 1 returns REV (default 3'd5) zero-extended to 16 bits. A write to address 1 changes nothing.
- R11: Addresses 2 to NREGS-1 (default NREGS=8) are read/write. A write to an address of NREGS or more is ignored, and reading such an address returns 0.
- R12: After reset the pull-low enable and `wr_valid_o` are 0, and writable register i holds 16'h5A00 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | High to pull the data line low |
| wr_valid_o | output | 1 | One-cycle write request valid, no back-pressure |
| wr_addr_o | output | 8 | Register address of the write request |
| wr_data_o | output | 16 | Data of the write request |
| rd_addr_i | input | 8 | Register bank read address |
| rd_data_o | output | 16 | Register bank read data (combinational) |

## Verification
Some properties are checked by assertions on every cycle:
- the pull-low enable moves only while the synchronized clock is low;
- a write request is a single-cycle pulse that follows an acknowledge;
- the first-byte acknowledge never rises for a foreign address or a read bit;
- a write to address 0 leaves the last register at its default.

Other behaviour only the bench scenarios can show:
- the exact byte order in the write request;
- that aborted, mismatched and read frames produce no request and leave registers untouched;
- that a start inside a frame is not taken as a new opening;
- the read-back of identity, revision and out-of-range addresses.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // bus idles high, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011010,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  output logic          pull_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int PW     = AW + DW;
  localparam int NBYTES = 1 + PW / 8;
  localparam int BIW    = $clog2(NBYTES);
  localparam logic [BIW-1:0] LAST_BYTE = BIW'(NBYTES - 1);

  rx_state_e      state_q;
  logic [3:0]     bit_cnt_q;
  logic [BIW-1:0] byte_idx_q;
  logic [7:0]     shreg_q;
  logic [PW-1:0]  payload_q;
  logic           pull_q;
  logic           valid_q;

  wire start_ev = sda_fall & scl_lvl;
  wire stop_ev  = sda_rise & scl_lvl;
  wire addr_ok  = (shreg_q == {DEV_ADDR, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      payload_q  <= '0;
      pull_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (state_q != ST_IDLE && (start_ev || stop_ev)) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_ev) begin
              state_q    <= ST_SHIFT;
              bit_cnt_q  <= '0;
              byte_idx_q <= '0;
            end
          end
          ST_SHIFT: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_lvl};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (byte_idx_q == '0) begin
                if (addr_ok) begin
                  state_q <= ST_ACK;
                  pull_q  <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q   <= ST_ACK;
                pull_q    <= 1'b1;
                payload_q <= {payload_q[PW-9:0], shreg_q};
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              pull_q    <= 1'b0;
              bit_cnt_q <= '0;
              if (byte_idx_q == LAST_BYTE) begin
                state_q <= ST_HOLD;
                valid_q <= 1'b1;
              end else begin
                byte_idx_q <= byte_idx_q + 1'b1;
                state_q    <= ST_SHIFT;
              end
            end
          end
          ST_HOLD: begin
            // wait for stop; extra clock pulses are ignored
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pull_o     = pull_q;
  assign wr_valid_o = valid_q;
  assign wr_addr_o  = payload_q[PW-1 -: AW];
  assign wr_data_o  = payload_q[DW-1:0];

  // R6
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_lvl);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7
  strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(pull_q));
  // R3 R4
  no_foreign_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_q) && byte_idx_q == '0) |-> (shreg_q[7:1] == DEV_ADDR && !shreg_q[0]));
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NREGS = 8,
  parameter logic [DW-1:0] CHIP_ID = 16'hC0DE,
  parameter logic [2:0] REV = 3'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IW = $clog2(NREGS);

  function automatic logic [DW-1:0] dflt(input int idx);
    return DW'(32'h5A00 + idx);
  endfunction

  logic [DW-1:0] vals [NREGS];
  wire soft_rst = wr_en && (wr_addr == '0);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_id
      assign vals[g] = CHIP_ID;
    end else if (g == 1) begin : g_rev
      assign vals[g] = DW'(REV);
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 q <= dflt(g);
        else if (soft_rst)                          q <= dflt(g);
        else if (wr_en && wr_addr == AW'(g))        q <= wr_data;
      end
      assign vals[g] = q;
    end
  end

  assign rd_data = (rd_addr < AW'(NREGS)) ? vals[rd_addr[IW-1:0]] : '0;

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (vals[NREGS-1] == dflt(NREGS-1)));
endmodule

// File: rtl/twowire_regbank.sv
module twowire_regbank #(
  parameter logic [6:0]  DEV_ADDR    = 7'b0011010,
  parameter int          AW          = 8,
  parameter int          DW          = 16,
  parameter int          NREGS       = 8,
  parameter logic [15:0] CHIP_ID     = 16'hC0DE,
  parameter logic [2:0]  REV         = 3'd5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  tw_frame_rx #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .pull_o(sda_pull_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

  tw_regfile #(.AW(AW), .DW(DW), .NREGS(NREGS), .CHIP_ID(DW'(CHIP_ID)), .REV(REV)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_valid_o), .wr_addr(wr_addr_o), .wr_data(wr_data_o),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o));
endmodule

// File: tb/twowire_regbank_tb.sv
`timescale 1ns/1ps
module twowire_regbank_tb;
  localparam time Q = 100ns;
  localparam logic [6:0] DEV = 7'b0011010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic pull;
  logic wr_valid;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;
  logic [7:0] rd_addr = '0;
  logic [15:0] rd_data;
  wire sda = pull ? 1'b0 : sda_m;

  int checks = 0;
  int fails = 0;
  int r6_viol = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  twowire_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_pull_o(pull), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor / scoreboard
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pull !== prev_pull && scl) r6_viol++;
      if (wr_valid) begin
        if (exp_q.size() == 0) chk("R8 unexpected write", {8'h0, wr_addr, wr_data}, 32'hFFFFFFFF);
        else chk("R7 write request", {8'h0, wr_addr, wr_data}, {8'h0, exp_q.pop_front()});
      end
    end
    prev_pull = pull;
  end

  task automatic bus_start();
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); sda_m = 1'b0; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(Q); scl = 1'b1; #(Q); sda_m = 1'b1; #(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q);
    end
    sda_m = 1'b1; #(Q); scl = 1'b1; #(Q);
    chk(req, 32'(sda == 1'b0), 32'(exp_ack));
    #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic write_frame(input logic [7:0] first, input logic [7:0] ra,
                             input logic [15:0] d, input logic ack_first, input string req);
    if (ack_first) exp_q.push_back({ra, d});
    bus_start();
    send_byte(first, ack_first, {req, " first-byte ack"});
    send_byte(ra, ack_first, {req, " R5 byte ack"});
    send_byte(d[15:8], ack_first, {req, " R5 byte ack"});
    send_byte(d[7:0], ack_first, {req, " R5 byte ack"});
    bus_stop();
    #(Q);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 pull at reset", 32'(pull), 0);
    chk("R12 valid at reset", 32'(wr_valid), 0);
    rd_chk(8'd2, 16'h5A02, "R12 reg2 default");
    rd_chk(8'd0, 16'hC0DE, "R10 chip id");
    rd_chk(8'd1, 16'h0005, "R10 revision");

    // R1 R2 R5 R7 basic writes
    write_frame({DEV, 1'b0}, 8'd2, 16'h1234, 1'b1, "R2");
    rd_chk(8'd2, 16'h1234, "R7 R1 reg2 written");
    write_frame({DEV, 1'b0}, 8'd7, 16'hBEEF, 1'b1, "R2");
    rd_chk(8'd7, 16'hBEEF, "R7 reg7 written");

    // R3 address mismatch
    write_frame({7'b0011011, 1'b0}, 8'd3, 16'hAAAA, 1'b0, "R3");
    rd_chk(8'd3, 16'h5A03, "R3 reg3 untouched");

    // R4 read request rejected
    write_frame({DEV, 1'b1}, 8'd4, 16'h5555, 1'b0, "R4");
    rd_chk(8'd4, 16'h5A04, "R4 reg4 untouched");

    // R8 abort by stop after first data byte
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R8 addr ack");
    send_byte(8'd3, 1'b1, "R8 reg ack");
    send_byte(8'h99, 1'b1, "R8 hi ack");
    bus_stop();
    #(Q);
    rd_chk(8'd3, 16'h5A03, "R8 stop abort no write");

    // R8 abort by start; that start does not open a new frame
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R8 addr ack");
    send_byte(8'd5, 1'b1, "R8 reg ack");
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, "R8 no ack after mid-frame start");
    send_byte(8'h11, 1'b0, "R8 silent");
    bus_stop();
    #(Q);
    rd_chk(8'd5, 16'h5A05, "R8 start abort no write");
    chk("R8 scoreboard empty", 32'(exp_q.size()), 0);

    // R10 write to revision ignored
    write_frame({DEV, 1'b0}, 8'd1, 16'hFFFF, 1'b1, "R10");
    rd_chk(8'd1, 16'h0005, "R10 revision unchanged");

    // R11 out-of-range address
    write_frame({DEV, 1'b0}, 8'd9, 16'h4321, 1'b1, "R11");
    rd_chk(8'd9, 16'h0000, "R11 out-of-range reads 0");
    rd_chk(8'd2, 16'h1234, "R11 reg2 unaffected");

    // R9 software reset
    write_frame({DEV, 1'b0}, 8'd0, 16'h0BAD, 1'b1, "R9");
    rd_chk(8'd2, 16'h5A02, "R9 reg2 restored");
    rd_chk(8'd7, 16'h5A07, "R9 reg7 restored");
    rd_chk(8'd0, 16'hC0DE, "R10 id after reset write");

    chk("R6 pull moved only with scl low", 32'(r6_viol), 0);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule